// File: doc/BRIEF.md
# Byte-Wide ADC Read Sequencer

This block runs a successive-approximation converter whose result appears on an 8-bit parallel bus. It is driven from the host side. A one-cycle start request makes it pull the read/convert and chip-select lines low together for a programmable number of clocks. That pulse begins a conversion. The block then waits for the converter's busy flag to go from low to high, which shows that the output register now holds the new result. Only then does it read the 16-bit result as two bytes: the upper half with byte-select low, then the lower half with byte-select high.

Before each byte is sampled, chip-select or byte-select has already settled for a programmable number of clocks, which covers the bus access time. The result is presented as `{upper, lower}` with a one-cycle done strobe. While a conversion or read is in progress the block deasserts ready and ignores start. The parallel/serial select line is held high at all times, so the converter always uses its parallel output.

Top module: `adc_byte_reader`

## Requirements
- R1: During and right after reset: read/convert high, chip-select high (inactive), byte-select low, done low, ready high, result word zero.
- R2: A start request sampled while ready is high drives read/convert and chip-select low together in the next cycle and holds them low for exactly CONV_CYCLES cycles. After that, both return high.
- R3: The parallel/serial select output is 1 at all times.
- R4: After the convert pulse, chip-select stays high until the block samples busy at 1 on one clock edge after having sampled it at 0 on the previous edge. That edge must fall at least one cycle after the convert pulse has ended. A busy rise during the pulse, or while idle, starts no read.
- R5: On that busy rising edge, the block drives chip-select low with read/convert high and byte-select low (byte-select 0 selects bus = upper byte, result bit 15 on bus bit 7). The bus is sampled as the upper byte ACCESS_CYCLES cycles later.
- R6: After sampling the upper byte, the block sets byte-select to 1 (bus = lower byte, result bit 0 on bus bit 0). It samples the lower byte ACCESS_CYCLES cycles after that change.
- R7: In the cycle after the lower byte is sampled, done is 1 for exactly one cycle. In that same cycle the word output equals {upper, lower}, chip-select is back high and byte-select is 0. The word output changes in no other cycle.
- R8: Ready is low from the cycle the convert pulse begins until the done cycle, and start is ignored during that time. Ready is high in the done cycle, and a start held high is accepted again at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken when ready_o is high |
| ready_o | output | 1 | Idle and able to accept a start |
| adc_rc_o | output | 1 | Read/convert line: 0 = convert, 1 = read |
| adc_cs_n_o | output | 1 | Chip-select, active low |
| adc_byte_sel_o | output | 1 | Byte-select: 0 = upper byte, 1 = lower byte |
| adc_par_sel_o | output | 1 | Parallel/serial select, held at 1 |
| adc_data_i | input | BYTE_W | Converter data bus |
| adc_busy_i | input | 1 | Converter busy flag, low while converting |
| word_o | output | 2*BYTE_W | Last assembled result |
| done_o | output | 1 | One-cycle strobe when word_o is updated |

## Verification
The assertions assume that busy is already synchronous to the system clock and changes at most once per cycle. They also assume that a low-to-high busy transition is the converter's signal that fresh data is waiting. The bench's converter model moves busy and the bus only at the falling clock edge. It drives the bus only while read/convert is high and chip-select is low, and it replaces its result only at the moment busy rises. Lone busy pulses are injected only while the block is idle, or to release a read that is still waiting. This keeps every busy rise the block acts on tied to a published result.

// File: rtl/adc_byte_reader.sv
module adc_byte_reader #(
  parameter int BYTE_W        = 8,
  parameter int CONV_CYCLES   = 3,
  parameter int ACCESS_CYCLES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  output logic                ready_o,
  output logic                adc_rc_o,
  output logic                adc_cs_n_o,
  output logic                adc_byte_sel_o,
  output logic                adc_par_sel_o,
  input  logic [BYTE_W-1:0]   adc_data_i,
  input  logic                adc_busy_i,
  output logic [2*BYTE_W-1:0] word_o,
  output logic                done_o
);
  localparam int MAXC = (CONV_CYCLES > ACCESS_CYCLES) ? CONV_CYCLES : ACCESS_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] CONV_LD = CW'(CONV_CYCLES - 1);
  localparam logic [CW-1:0] ACC_LD  = CW'(ACCESS_CYCLES - 1);

  typedef enum logic [2:0] {S_IDLE, S_CONV, S_WAIT, S_HI, S_LO} state_t;

  state_t            st;
  logic [CW-1:0]     cnt;
  logic              busy_q;
  logic [BYTE_W-1:0] hi_q;

  wire busy_rise = adc_busy_i & ~busy_q;
  wire cnt_zero  = (cnt == '0);

  assign ready_o       = (st == S_IDLE);
  assign adc_par_sel_o = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st             <= S_IDLE;
      cnt            <= '0;
      busy_q         <= 1'b1;
      hi_q           <= '0;
      word_o         <= '0;
      done_o         <= 1'b0;
      adc_rc_o       <= 1'b1;
      adc_cs_n_o     <= 1'b1;
      adc_byte_sel_o <= 1'b0;
    end else begin
      busy_q <= adc_busy_i;
      done_o <= 1'b0;
      unique case (st)
        S_IDLE: if (start_i) begin
          adc_rc_o   <= 1'b0;
          adc_cs_n_o <= 1'b0;
          cnt        <= CONV_LD;
          st         <= S_CONV;
        end
        S_CONV: if (cnt_zero) begin
          adc_rc_o   <= 1'b1;
          adc_cs_n_o <= 1'b1;
          st         <= S_WAIT;
        end else cnt <= cnt - 1'b1;
        S_WAIT: if (busy_rise) begin
          adc_cs_n_o     <= 1'b0;
          adc_byte_sel_o <= 1'b0;
          cnt            <= ACC_LD;
          st             <= S_HI;
        end
        S_HI: if (cnt_zero) begin
          hi_q           <= adc_data_i;
          adc_byte_sel_o <= 1'b1;
          cnt            <= ACC_LD;
          st             <= S_LO;
        end else cnt <= cnt - 1'b1;
        S_LO: if (cnt_zero) begin
          word_o         <= {hi_q, adc_data_i};
          done_o         <= 1'b1;
          adc_cs_n_o     <= 1'b1;
          adc_byte_sel_o <= 1'b0;
          st             <= S_IDLE;
        end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_byte_reader_chk.sv
module adc_byte_reader_chk #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic                ready_o,
  input logic                adc_rc_o,
  input logic                adc_cs_n_o,
  input logic                adc_byte_sel_o,
  input logic                adc_par_sel_o,
  input logic                adc_busy_i,
  input logic [2*BYTE_W-1:0] word_o,
  input logic                done_o
);
  p_start_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && start_i) |=> (!adc_rc_o && !adc_cs_n_o));

  p_conv_with_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_rc_o |-> !adc_cs_n_o);

  p_par_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_par_sel_o);

  p_read_after_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(adc_cs_n_o) && adc_rc_o) |-> ($past(adc_busy_i) && !$past(adc_busy_i, 2)));

  p_bsel_in_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    adc_byte_sel_o |-> (adc_rc_o && !adc_cs_n_o));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_word_only_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_o) |-> done_o);

  p_done_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ready_o && adc_cs_n_o));

  p_busy_no_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_cs_n_o && !done_o) |-> !ready_o);
endmodule

bind adc_byte_reader adc_byte_reader_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .ready_o(ready_o),
  .adc_rc_o(adc_rc_o), .adc_cs_n_o(adc_cs_n_o), .adc_byte_sel_o(adc_byte_sel_o),
  .adc_par_sel_o(adc_par_sel_o), .adc_busy_i(adc_busy_i), .word_o(word_o),
  .done_o(done_o)
);

// File: tb/sim_adc_byte_reader.sv
module sim_adc_byte_reader;
  localparam int CLK_P  = 10;
  localparam int CONV_N = 3;
  localparam int ACC_N  = 4;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic ready_o, rc, cs_n, bsel, par, done_o;
  logic [15:0] word_o;
  logic [7:0]  adc_data;
  logic        adc_busy = 1'b1;
  logic [15:0] adc_word = 16'h0000, pend_word = 16'h0000;
  int lag = 2, convt = 6, glitch_req = 0, glitch_seen = 0;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  adc_byte_reader #(.BYTE_W(8), .CONV_CYCLES(CONV_N), .ACCESS_CYCLES(ACC_N)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ready_o(ready_o),
    .adc_rc_o(rc), .adc_cs_n_o(cs_n), .adc_byte_sel_o(bsel), .adc_par_sel_o(par),
    .adc_data_i(adc_data), .adc_busy_i(adc_busy), .word_o(word_o), .done_o(done_o)
  );

  // converter model: bus driven only in read state, result published as busy rises
  assign adc_data = (rc && !cs_n) ? (bsel ? adc_word[7:0] : adc_word[15:8]) : 8'hEE;

  int ph = 0;
  bit in_conv = 0, gl_hold = 0;
  always @(negedge clk) begin
    if (in_conv) begin
      ph++;
      if (ph == lag) adc_busy = 1'b0;
      if (ph == lag + convt) begin
        adc_word = pend_word;
        adc_busy = 1'b1;
        in_conv  = 0;
      end
    end else if (!rc && !cs_n) begin
      in_conv = 1;
      ph = 0;
    end else if (gl_hold) begin
      adc_busy = 1'b1;
      gl_hold = 0;
    end else if (glitch_req != glitch_seen) begin
      glitch_seen++;
      adc_busy = 1'b0;
      gl_hold = 1;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle-time %0t", tag, act, exp, $time);
    end
  endtask

  // timeline reference model, compared every cycle
  int cyc = 0, t_start = -1, t_rise = -1;
  bit prev_busy = 1;
  logic [15:0] exp_word = 16'h0000;
  always @(posedge clk) begin
    #(CLK_P/4);
    cyc++;
    if (!rst_n) begin
      t_start = -1; t_rise = -1; prev_busy = 1;
      chk("R1 rc", {15'd0, rc}, 16'd1);
      chk("R1 cs_n", {15'd0, cs_n}, 16'd1);
      chk("R1 bsel", {15'd0, bsel}, 16'd0);
      chk("R1 done", {15'd0, done_o}, 16'd0);
      chk("R1 ready", {15'd0, ready_o}, 16'd1);
      chk("R1 word", word_o, 16'h0000);
    end else begin
      bit conv, rd, xb, xd, xr;
      if (t_start < 0 && start_i) t_start = cyc;
      else if (t_start >= 0 && t_rise < 0 && cyc >= t_start + CONV_N + 1 &&
               adc_busy && !prev_busy) t_rise = cyc;
      prev_busy = adc_busy;
      conv = (t_start >= 0) && (cyc < t_start + CONV_N);
      rd   = (t_rise >= 0) && (cyc < t_rise + 2*ACC_N);
      xb   = (t_rise >= 0) && (cyc >= t_rise + ACC_N) && (cyc < t_rise + 2*ACC_N);
      xd   = (t_rise >= 0) && (cyc == t_rise + 2*ACC_N);
      xr   = (t_start < 0) || xd;
      if (xd) exp_word = adc_word;
      chk("R2 rc", {15'd0, rc}, {15'd0, !conv});
      chk(t_rise < 0 ? "R4 cs_n" : "R5 cs_n", {15'd0, cs_n}, {15'd0, !(conv || rd)});
      chk("R6 bsel", {15'd0, bsel}, {15'd0, xb});
      chk("R7 done", {15'd0, done_o}, {15'd0, xd});
      chk("R7 word", word_o, exp_word);
      chk("R8 ready", {15'd0, ready_o}, {15'd0, xr});
      chk("R3 par", {15'd0, par}, 16'd1);
      if (xd) begin t_start = -1; t_rise = -1; end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic wait_done(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (done_o) return;
    end
  endtask

  task automatic run_conv(input logic [15:0] w, input int l, input int c);
    @(negedge clk);
    pend_word = w; lag = l; convt = c;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(200);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_conv(16'hA55A, 2, 6);        // R5 R6 R7 basic read
    run_conv(16'hFFFF, 8, 3);        // R4 busy falls late, after pulse
    run_conv(16'h0000, 1, 12);       // R7 zero word
    run_conv(16'h8001, 3, 5);        // R5 R6 byte order edge bits
    // R4 idle busy pulse must not start a read
    @(negedge clk); glitch_req++;
    repeat (10) @(negedge clk);
    // R8 start held high across two conversions
    @(negedge clk); pend_word = 16'h1234; lag = 2; convt = 4; start_i = 1'b1;
    wait_done(200);
    pend_word = 16'h5678;
    wait_done(200);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    // R4 busy rise inside the convert pulse is ignored; later pulse releases the read
    @(negedge clk); pend_word = 16'h0F0F; lag = 1; convt = 1; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (12) @(negedge clk);
    glitch_req++;
    wait_done(100);
    repeat (4) @(negedge clk);
    run_conv(16'hC3E1, 2, 3);        // R2 R7 recovery after the stall
    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end
endmodule